// File: doc/BRIEF.md
# I2C Transfer Command Sequencer

This block sits in front of an I2C byte controller and turns one host command into the full series of register steps that a transfer needs. The command names a 7-bit chip, up to four offset bytes, a payload length and an operation: write, read or probe. The sequencer then drives the controller's control and data registers itself. It polls the interrupt flag, checks every returned status code against the code that step should give, and always closes the bus with a STOP.

Payload bytes for a write are taken from a simple stream input with a take strobe. Bytes received by a read come out on a data output qualified by a one-cycle valid. At the end the block pulses `done` and holds a 32-bit result word. The word is zero on success. On failure it packs the error class, the last control value, the last status value and the status that was expected. Bit timing and the bus pins belong to the external controller. The poll interval, in clock cycles, and the poll limit are parameters.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ctl_wr`, `dat_wr` and `rx_valid` are low and `err_word` is zero.
- R2: `cmd_valid` is accepted only while `busy` is low. A command presented while busy has no effect on the bytes sent, on the number of STOPs issued or on the result.
- R3: Each control write leaves control bit 3 (interrupt flag) at 0, which clears it. Enable is bit 6, START is bit 5, STOP is bit 4 and ACK is bit 2. A write (`cmd_op`=0) issues START (0x60), expecting status 0x08. It then sends address byte {chip,0}, expecting 0x18. Next come the offset bytes, then `cmd_len` payload bytes taken from `tx_data`, each expecting 0x28.
- R4: Offset bytes go out from index `cmd_olen`-1 down to index 0, where byte k is `cmd_offset[8k+7:8k]`.
- R5: A read (`cmd_op`=1) with a nonzero offset length works as follows. It sends the write address and the offset bytes, then a repeated START expecting 0x10 with no STOP in between, then {chip,1} expecting 0x40. With a zero offset length it goes straight from the first START to {chip,1}.
- R6: In a read, every received byte but the last is acknowledged: control 0x44, expecting 0x50. The last byte is not: control 0x40, expecting 0x58. Each byte read appears on `rx_data` with a one-cycle `rx_valid`.
- R7: A probe (`cmd_op`=2 or 3) sends {chip,1} after START and receives one dummy byte with NAK, expecting 0x58. It does not raise `rx_valid`.
- R8: A step whose flag is set while the status differs from the expected code ends the transfer with `err_word` = {0x01, control read, status read, expected}.
- R9: A step whose flag stays clear for MAX_POLLS polls, one every POLL_DIV cycles, ends with `err_word` = {0x02, control read, status read, expected}.
- R10: Every command ends with exactly one STOP write (0x50), after which the block waits for status 0xF8. A STOP timeout gives {0x02, control, status, 0xF8}, but only if no earlier error was recorded. An earlier error takes precedence.
- R11: `done` is high for exactly one cycle per command, after which the block is idle. `err_word` holds its value until the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 write, 1 read, 2 or 3 probe |
| cmd_chip | input | 7 | Target chip address |
| cmd_offset | input | 32 | Offset bytes, byte k in bits 8k+7:8k |
| cmd_olen | input | 3 | Number of offset bytes, 0 to 4 |
| cmd_len | input | LEN_W | Payload byte count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_word | output | 32 | Result word, zero on success |
| ctl_wr | output | 1 | Control register write strobe |
| ctl_val | output | 8 | Control register write value |
| dat_wr | output | 1 | Data register write strobe |
| dat_val | output | 8 | Data register write value |
| ctl_rd | input | 8 | Controller control register, bit 3 is the flag |
| sts_rd | input | 8 | Controller status register |
| dat_rd | input | 8 | Controller received data register |
| tx_data | input | 8 | Next payload byte to send |
| tx_take | output | 1 | Payload byte consumed |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | `rx_data` valid for one cycle |

## Verification
The assertions assume the following about the inputs: `cmd_olen` never exceeds 4, `tx_data` always holds a byte when `tx_take` fires, and the controller only changes its flag and status after a control write. The bench keeps within these limits. Its controller model raises the flag a fixed latency after each non-STOP write and sets status 0xF8 after a STOP. Faults are injected only at chosen step indices: a wrong status, a flag that never rises, or a STOP that never completes. The offset lengths used stay between 0 and 4, and the payload stream is a counter that is always ready.

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq #(
  parameter int LEN_W     = 8,
  parameter int POLL_DIV  = 500,
  parameter int MAX_POLLS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_chip,
  input  logic [31:0]      cmd_offset,
  input  logic [2:0]       cmd_olen,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic [31:0]      err_word,
  output logic             ctl_wr,
  output logic [7:0]       ctl_val,
  output logic             dat_wr,
  output logic [7:0]       dat_val,
  input  logic [7:0]       ctl_rd,
  input  logic [7:0]       sts_rd,
  input  logic [7:0]       dat_rd,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic [7:0]       rx_data,
  output logic             rx_valid
);
  localparam int PW = $clog2(POLL_DIV + 1);
  localparam int TW = $clog2(MAX_POLLS + 1);
  localparam logic [7:0] C_EN = 8'h40, C_START = 8'h20, C_STOP = 8'h10, C_ACK = 8'h04;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_STOP, S_SWAIT, S_DONE} st_t;
  typedef enum logic [2:0] {PH_START, PH_WADDR, PH_OFS, PH_RSTART, PH_RADDR, PH_TX, PH_RX} ph_t;

  st_t             state;
  ph_t             phase, nxt;
  logic [1:0]      op;
  logic [6:0]      chip;
  logic [31:0]     ofs;
  logic [2:0]      olen;
  logic [1:0]      oidx;
  logic [LEN_W-1:0] rem;
  logic [7:0]      expc;
  logic [PW-1:0]   pcnt;
  logic [TW-1:0]   tcnt;
  logic            fin, ack, tick, is_rd, is_wr;

  assign is_wr = (op == 2'd0);
  assign is_rd = (op == 2'd1);
  assign ack   = is_rd && (rem > 1);
  assign tick  = (pcnt == PW'(POLL_DIV - 1));
  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);

  always_comb begin
    ctl_val = C_EN;
    dat_val = 8'h00;
    dat_wr  = 1'b0;
    expc    = 8'h28;
    case (phase)
      PH_START:  begin ctl_val = C_EN | C_START; expc = 8'h08; end
      PH_RSTART: begin ctl_val = C_EN | C_START; expc = 8'h10; end
      PH_WADDR:  begin dat_val = {chip, 1'b0}; dat_wr = 1'b1; expc = 8'h18; end
      PH_RADDR:  begin dat_val = {chip, 1'b1}; dat_wr = 1'b1; expc = 8'h40; end
      PH_OFS:    begin dat_val = ofs[{oidx, 3'b000} +: 8]; dat_wr = 1'b1; end
      PH_TX:     begin dat_val = tx_data; dat_wr = 1'b1; end
      PH_RX:     begin ctl_val = ack ? (C_EN | C_ACK) : C_EN; expc = ack ? 8'h50 : 8'h58; end
      default: ;
    endcase
    if (state == S_STOP) ctl_val = C_EN | C_STOP;
    dat_wr = dat_wr && (state == S_ISSUE);
  end

  assign ctl_wr  = (state == S_ISSUE) || (state == S_STOP);
  assign tx_take = (state == S_ISSUE) && (phase == PH_TX);

  always_comb begin
    nxt = phase;
    fin = 1'b0;
    case (phase)
      PH_START:  nxt = (is_wr || (is_rd && olen != 0)) ? PH_WADDR : PH_RADDR;
      PH_WADDR:  if (olen != 0) nxt = PH_OFS;
                 else if (rem != 0) nxt = PH_TX;
                 else fin = 1'b1;
      PH_OFS:    if (oidx != 0) nxt = PH_OFS;
                 else if (is_rd) nxt = PH_RSTART;
                 else if (rem != 0) nxt = PH_TX;
                 else fin = 1'b1;
      PH_RSTART: nxt = PH_RADDR;
      PH_RADDR:  if (rem != 0) nxt = PH_RX;
                 else fin = 1'b1;
      default:   fin = (rem <= 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= PH_START;
      op       <= 2'd0;
      chip     <= 7'd0;
      ofs      <= 32'd0;
      olen     <= 3'd0;
      oidx     <= 2'd0;
      rem      <= '0;
      pcnt     <= '0;
      tcnt     <= '0;
      err_word <= 32'd0;
      rx_data  <= 8'd0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op       <= cmd_op;
          chip     <= cmd_chip;
          ofs      <= cmd_offset;
          olen     <= cmd_olen;
          oidx     <= 2'(cmd_olen - 3'd1);
          rem      <= cmd_op[1] ? LEN_W'(1) : cmd_len;
          phase    <= PH_START;
          err_word <= 32'd0;
          state    <= S_ISSUE;
        end
        S_ISSUE, S_STOP: begin
          pcnt  <= '0;
          tcnt  <= '0;
          state <= (state == S_ISSUE) ? S_WAIT : S_SWAIT;
        end
        S_WAIT: begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) begin
            if (ctl_rd[3]) begin
              if (sts_rd == expc) begin
                if (phase == PH_OFS) oidx <= oidx - 2'd1;
                if (phase == PH_TX || phase == PH_RX) rem <= rem - 1'b1;
                if (phase == PH_RX && is_rd) begin
                  rx_data  <= dat_rd;
                  rx_valid <= 1'b1;
                end
                phase <= nxt;
                state <= fin ? S_STOP : S_ISSUE;
              end else begin
                err_word <= {8'h01, ctl_rd, sts_rd, expc};
                state    <= S_STOP;
              end
            end else if (tcnt == TW'(MAX_POLLS - 1)) begin
              err_word <= {8'h02, ctl_rd, sts_rd, expc};
              state    <= S_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_SWAIT: begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) begin
            if (sts_rd == 8'hF8) begin
              state <= S_DONE;
            end else if (tcnt == TW'(MAX_POLLS - 1)) begin
              if (err_word == 32'd0) err_word <= {8'h02, ctl_rd, sts_rd, 8'hF8};
              state <= S_DONE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic [31:0] err_word,
  input logic        ctl_wr,
  input logic [7:0]  ctl_val,
  input logic        dat_wr,
  input logic        rx_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ctl_wr && !dat_wr); // R1
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |-> !ctl_val[3]); // R3
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |-> !(ctl_val[5] && ctl_val[4])); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !cmd_valid) |=> $stable(err_word)); // R11
  AST_ERR_CLASS: assert property (@(posedge clk) disable iff (!rst_n) done |-> err_word[31:24] <= 8'h02); // R8
  AST_RX_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> busy); // R6
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err_word(err_word), .ctl_wr(ctl_wr), .ctl_val(ctl_val), .dat_wr(dat_wr), .rx_valid(rx_valid)
);

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;
  localparam int LAT = 5;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  chip;
    logic [2:0]  olen;
    logic [31:0] ofs;
    logic [7:0]  len;
    logic [2:0]  fk;    // bit0 wrong status, bit1 flag never rises, bit2 STOP never completes
    logic [3:0]  fat;
    logic [7:0]  fsts;
    logic [31:0] expe;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 7'h50, 3'd2, 32'h0000_1234, 8'd2, 3'd0, 4'd0, 8'h00, 32'h0},          // R3 R4
    '{2'd1, 7'h50, 3'd1, 32'h0000_0077, 8'd3, 3'd0, 4'd0, 8'h00, 32'h0},          // R5 R6
    '{2'd1, 7'h21, 3'd0, 32'h0,         8'd1, 3'd0, 4'd0, 8'h00, 32'h0},          // R5 R6
    '{2'd2, 7'h48, 3'd0, 32'h0,         8'd0, 3'd0, 4'd0, 8'h00, 32'h0},          // R7
    '{2'd2, 7'h48, 3'd0, 32'h0,         8'd0, 3'd1, 4'd1, 8'h48, 32'h0148_4840},  // R8
    '{2'd0, 7'h10, 3'd4, 32'hA1B2_C3D4, 8'd0, 3'd1, 4'd3, 8'h30, 32'h0148_3028},  // R8
    '{2'd1, 7'h21, 3'd0, 32'h0,         8'd2, 3'd2, 4'd0, 8'h00, 32'h0260_F808},  // R9
    '{2'd0, 7'h33, 3'd0, 32'h0,         8'd1, 3'd4, 4'd0, 8'h00, 32'h0250_28F8},  // R10
    '{2'd0, 7'h33, 3'd0, 32'h0,         8'd1, 3'd5, 4'd1, 8'h20, 32'h0148_2018}   // R10
  };

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        cmd_valid = 0;
  logic [1:0]  cmd_op = 0;
  logic [6:0]  cmd_chip = 0;
  logic [31:0] cmd_offset = 0;
  logic [2:0]  cmd_olen = 0;
  logic [7:0]  cmd_len = 0;
  logic        busy, done, ctl_wr, dat_wr, tx_take, rx_valid;
  logic [31:0] err_word;
  logic [7:0]  ctl_val, dat_val, rx_data, tx_data;
  logic [7:0]  m_ctl, m_sts, m_dat, m_pend;

  i2c_cmd_seq #(.LEN_W(8), .POLL_DIV(3), .MAX_POLLS(6)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_chip(cmd_chip),
    .cmd_offset(cmd_offset), .cmd_olen(cmd_olen), .cmd_len(cmd_len), .busy(busy), .done(done),
    .err_word(err_word), .ctl_wr(ctl_wr), .ctl_val(ctl_val), .dat_wr(dat_wr), .dat_val(dat_val),
    .ctl_rd(m_ctl), .sts_rd(m_sts), .dat_rd(m_dat), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // controller model
  logic       clr = 0;
  logic [2:0] fk = 0;
  logic [3:0] fat = 0;
  logic [7:0] fsts = 0;
  int m_lat, m_ev, n_sent, n_recv, n_rs, n_stop, n_tx;
  bit m_bus, m_after, m_rmode, m_pstop;
  logic [7:0]  sent [16];
  logic [15:0] ackmask;
  logic [7:0] s;

  assign tx_data = 8'hC0 + 8'(n_tx);

  always @(posedge clk) begin
    if (clr) begin
      m_lat <= 0; m_ev <= 0; n_sent <= 0; n_recv <= 0; n_rs <= 0; n_stop <= 0; n_tx <= 0;
      m_bus <= 0; m_after <= 0; m_rmode <= 0; m_pstop <= 0; ackmask <= 0;
      m_ctl <= 8'h40; m_sts <= 8'hF8; m_dat <= 8'h00; m_pend <= 8'h00;
    end else begin
      if (tx_take) n_tx <= n_tx + 1;
      if (dat_wr && n_sent < 16) begin sent[n_sent] <= dat_val; n_sent <= n_sent + 1; end
      if (m_lat > 0) begin
        m_lat <= m_lat - 1;
        if (m_lat == 1) begin
          if (m_pstop) begin if (!fk[2]) m_sts <= 8'hF8; end
          else begin m_ctl <= m_ctl | 8'h08; m_sts <= m_pend; end
        end
      end
      if (ctl_wr) begin
        m_ctl <= ctl_val;
        if (ctl_val[4]) begin
          n_stop <= n_stop + 1; m_bus <= 0; m_after <= 0; m_rmode <= 0; m_pstop <= 1; m_lat <= LAT;
        end else begin
          m_pstop <= 0;
          if (ctl_val[5]) begin
            s = m_bus ? 8'h10 : 8'h08;
            if (m_bus) n_rs <= n_rs + 1;
            m_bus <= 1; m_after <= 1;
          end else if (m_after) begin
            s = dat_val[0] ? 8'h40 : 8'h18;
            m_rmode <= dat_val[0]; m_after <= 0;
          end else if (m_rmode) begin
            s = ctl_val[2] ? 8'h50 : 8'h58;
            ackmask[n_recv[3:0]] <= ctl_val[2];
            m_dat <= 8'h5A ^ 8'(n_recv);
            n_recv <= n_recv + 1;
          end else s = 8'h28;
          if (fk[0] && m_ev == int'(fat)) s = fsts;
          m_pend <= s;
          m_lat  <= (fk[1] && m_ev == int'(fat)) ? 0 : LAT;
          m_ev   <= m_ev + 1;
        end
      end
    end
  end

  // rx monitor
  int n_rxv, rx_bad;
  always @(negedge clk) begin
    if (clr) begin n_rxv <= 0; rx_bad <= 0; end
    else if (rx_valid) begin
      if (rx_data !== (8'h5A ^ 8'(n_rxv))) rx_bad <= rx_bad + 1;
      n_rxv <= n_rxv + 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input vec_t v);
    @(negedge clk);
    fk = v.fk; fat = v.fat; fsts = v.fsts; clr = 1;
    @(negedge clk);
    clr = 0;
    cmd_op = v.op; cmd_chip = v.chip; cmd_offset = v.ofs; cmd_olen = v.olen; cmd_len = v.len;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
    chk(ok, "R11 done", 32'(ok), 32'd1);
  endtask

  task automatic check_seq(input vec_t v);
    logic [7:0] eb [16];
    int ne = 0;
    bit same;
    if (v.op == 2'd0 || (v.op == 2'd1 && v.olen != 0)) begin
      eb[ne] = {v.chip, 1'b0}; ne++;
      for (int k = int'(v.olen) - 1; k >= 0; k--) begin eb[ne] = v.ofs[8*k +: 8]; ne++; end
    end
    if (v.op == 2'd0) begin
      for (int k = 0; k < int'(v.len); k++) begin eb[ne] = 8'hC0 + 8'(k); ne++; end
    end else begin
      eb[ne] = {v.chip, 1'b1}; ne++;
    end
    same = (ne == n_sent);
    for (int k = 0; k < ne && k < 16; k++) if (sent[k] !== eb[k]) same = 0;
    chk(same, "R3 R4 byte order", 32'(n_sent), 32'(ne));
    if (v.op == 2'd1) begin
      chk(n_rs == (v.olen != 0 ? 1 : 0), "R5 repeated START", 32'(n_rs), 32'(v.olen != 0));
      chk(n_rxv == int'(v.len) && rx_bad == 0, "R6 rx bytes", 32'(n_rxv), 32'(v.len));
      chk(ackmask == 16'((1 << (int'(v.len) - 1)) - 1), "R6 ack pattern", 32'(ackmask),
          32'((1 << (int'(v.len) - 1)) - 1));
    end else if (v.op[1]) begin
      chk(n_recv == 1 && ackmask == 0 && n_rxv == 0, "R7 probe dummy NAK", 32'(n_rxv), 32'd0);
    end
  endtask

  initial begin
    bit ok;
    vec_t v;
    clr = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ctl_wr && !dat_wr && !rx_valid && err_word == 0, "R1 reset",
        {busy, done, ctl_wr, dat_wr, rx_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    clr = 0;

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      start_cmd(v);
      wait_done(ok);
      if (ok) begin
        chk(err_word == v.expe, (v.fk == 0) ? "R3 result" : "R8 R9 R10 error word", err_word, v.expe);
        chk(n_stop == 1, "R10 single STOP", 32'(n_stop), 32'd1);
        if (v.fk == 0) check_seq(v);
        @(negedge clk);
        chk(!done && !busy && err_word == v.expe, "R11 pulse and hold", {done, busy}, 32'd0);
      end
    end

    // R2: a second command while busy changes nothing
    v = VEC[0];
    start_cmd(v);
    repeat (12) @(negedge clk);
    cmd_op = 2'd2; cmd_chip = 7'h7F; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    wait_done(ok);
    chk(err_word == 0 && n_stop == 1, "R2 busy command ignored", err_word, 32'd0);
    check_seq(v);
    repeat (20) @(negedge clk);
    chk(!busy && n_sent == 5, "R2 no extra command", 32'(n_sent), 32'd5);

    // R11: result held across idle cycles
    v = VEC[7];
    start_cmd(v);
    wait_done(ok);
    repeat (10) @(negedge clk);
    chk(err_word == v.expe, "R11 hold", err_word, v.expe);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule